// File: doc/BRIEF.md
# Cascadable Dual-Byte Pulse Accumulator

This block holds two byte-wide pulse counters behind a small register bus. With the merge bit clear, each byte counts active edges on its own input pin, provided its own enable bit is set. With the merge bit set, the two bytes form one 16-bit accumulator: the upper counter is the high byte and the lower counter is the low byte, fed by the carry out of the low byte. The merge bit works on its own and needs no other timer enable.

While merged, the accumulator takes its input from pin A, which it shares with a capture channel of the wider timer. It runs in one of two modes. In event mode it counts edges of pin A. In gated mode it counts timebase ticks, supplied by an external prescaler, while pin A sits at its active level. A sticky overflow flag marks each wrap of the 16-bit count. An edge flag marks an active edge, or the trailing edge of the gate, and works only while merged. Both flags are cleared by writing 1 to them, and each can raise the interrupt line. Both pins pass through a synchroniser before edge detection.

The register bus is plain control access with no handshake. A write takes effect at the clock edge where `bus_we` is high, and reads are combinational from `bus_addr`.

Top module: `pulse_acc_top`

## Requirements
- R1: After reset every register reads 0. In the control register (address 0), bits 7, 3 and 2 always read 0.
- R2: With merge (control bit 6) clear, the low byte (address 3) counts active edges of `pin_a` only when byte-enable bit 0 (address 1) is set. The high byte (address 2) counts active edges of `pin_b` only when byte-enable bit 1 is set. The active edge is the one selected by the polarity bit (control bit 4): 0 selects falling and 1 selects rising.
- R3: With merge set and mode (control bit 5) clear, the 16-bit count {address 2, address 3} increments on each active edge of `pin_a`, and the low byte carries into the high byte.
- R4: While merged, the byte-enable bits have no effect, `pin_b` is ignored, and the count advances by at most one per cycle.
- R5: With merge and mode set, the count increments once per cycle in which `tick` is high while the gate is open. The gate is open while `pin_a` is high when polarity is 0, and while `pin_a` is low when polarity is 1. Ticks are ignored while the gate is closed.
- R6: The edge flag (address 4, bit 0) sets on an active edge of `pin_a` in event mode, and on the trailing edge of the gate in gated mode. It can set only while merged.
- R7: When the merged count wraps from 0xFFFF to 0x0000, the sticky overflow flag (address 4, bit 1) sets.
- R8: Writing 1 to a flag bit at address 4 clears that flag. Writing 0 leaves it unchanged. A flag set in the same cycle as a clear wins.
- R9: `irq` is high while (overflow flag AND control bit 1) OR (edge flag AND control bit 0).
- R10: A write to either count byte loads that byte directly. That cycle's increment is dropped across both bytes, and no overflow is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | BYTE_W | Write data |
| bus_rdata | output | BYTE_W | Read data for `bus_addr` |
| pin_a | input | 1 | Shared pulse input (low byte or 16-bit source) |
| pin_b | input | 1 | High-byte pulse input in split mode |
| tick | input | 1 | Prescaled timebase strobe for gated mode |
| ovf_flag | output | 1 | Sticky overflow flag |
| edge_flag | output | 1 | Sticky edge flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: BYTE_W = 8 and SYNC_STAGES = 2. An edge therefore reaches the counters three clock edges after the pin changes, and the bench can time a bus write to land on exactly the cycle of an increment. With 8-bit bytes, a preload of 0xFFFF brings the 16-bit wrap and the overflow flag within one pulse. A preload of 0x00FF exercises the low-to-high carry.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_BEN    = 3'd1,
    A_CNT_HI = 3'd2,
    A_CNT_LO = 3'd3,
    A_FLAGS  = 3'd4
  } pa_addr_e;

  // control register bit positions
  localparam int C_MERGE   = 6;
  localparam int C_GATED   = 5;
  localparam int C_POL     = 4;
  localparam int C_OVF_IE  = 1;
  localparam int C_EDGE_IE = 0;

  // flag register bit positions
  localparam int F_OVF  = 1;
  localparam int F_EDGE = 0;

  typedef struct packed {
    logic merge;
    logic gated;
    logic pol;
    logic ovf_ie;
    logic edge_ie;
  } pa_ctrl_t;
endpackage

// File: rtl/pa_sync_edge.sv
module pa_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] shift_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      shift_q <= {shift_q[STAGES-2:0], pin};
      prev_q  <= shift_q[STAGES-1];
    end
  end

  assign level = shift_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;
endmodule

// File: rtl/pa_byte_cnt.sv
module pa_byte_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         at_max
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (inc)  q <= q + 1'b1;
  end

  assign at_max = &q;
endmodule

// File: rtl/pa_event_sel.sv
module pa_event_sel
  import pa_pkg::*;
(
  input  pa_ctrl_t   ctrl,
  input  logic [1:0] ben,
  input  logic       lvl_a,
  input  logic       rise_a,
  input  logic       fall_a,
  input  logic       rise_b,
  input  logic       fall_b,
  input  logic       tick,
  input  logic       lo_max,
  input  logic       hi_max,
  input  logic       hold,
  output logic       lo_inc,
  output logic       hi_inc,
  output logic       edge_set,
  output logic       ovf_set
);
  logic act_a, act_b, gate_open, step;

  always_comb begin
    act_a     = ctrl.pol ? rise_a : fall_a;
    act_b     = ctrl.pol ? rise_b : fall_b;
    gate_open = ctrl.pol ? ~lvl_a : lvl_a;
    step      = ctrl.gated ? (tick & gate_open) : act_a;
    if (ctrl.merge) begin
      lo_inc  = step & ~hold;
      hi_inc  = step & lo_max & ~hold;
      ovf_set = step & lo_max & hi_max & ~hold;
    end else begin
      lo_inc  = ben[0] & act_a & ~hold;
      hi_inc  = ben[1] & act_b & ~hold;
      ovf_set = 1'b0;
    end
    // trailing gate edge coincides with the selected edge of pin_a
    edge_set = ctrl.merge & act_a;
  end
endmodule

// File: rtl/pulse_acc_top.sv
module pulse_acc_top
  import pa_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              pin_a,
  input  logic              pin_b,
  input  logic              tick,
  output logic              ovf_flag,
  output logic              edge_flag,
  output logic              irq
);
  localparam int NPIN = 2;

  pa_ctrl_t          ctrl_q;
  logic [1:0]        ben_q;
  logic              ovf_q, edge_q;
  logic [NPIN-1:0]   pins, lvl, rise, fall;
  logic [BYTE_W-1:0] cnt_hi, cnt_lo;
  logic              hi_max, lo_max, lo_inc, hi_inc, edge_set, ovf_set;
  logic              wr_ctrl, wr_ben, wr_hi, wr_lo, wr_flags;

  assign pins = {pin_b, pin_a};

  genvar gi;
  generate
    for (gi = 0; gi < NPIN; gi++) begin : g_sync
      pa_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(pins[gi]),
        .level(lvl[gi]), .rise(rise[gi]), .fall(fall[gi])
      );
    end
  endgenerate

  assign wr_ctrl  = bus_we && (bus_addr == A_CTRL);
  assign wr_ben   = bus_we && (bus_addr == A_BEN);
  assign wr_hi    = bus_we && (bus_addr == A_CNT_HI);
  assign wr_lo    = bus_we && (bus_addr == A_CNT_LO);
  assign wr_flags = bus_we && (bus_addr == A_FLAGS);

  pa_event_sel u_sel (
    .ctrl(ctrl_q), .ben(ben_q),
    .lvl_a(lvl[0]), .rise_a(rise[0]), .fall_a(fall[0]),
    .rise_b(rise[1]), .fall_b(fall[1]),
    .tick(tick), .lo_max(lo_max), .hi_max(hi_max),
    .hold(wr_hi | wr_lo),
    .lo_inc(lo_inc), .hi_inc(hi_inc),
    .edge_set(edge_set), .ovf_set(ovf_set)
  );

  pa_byte_cnt #(.W(BYTE_W)) u_lo (
    .clk(clk), .rst_n(rst_n), .load(wr_lo), .load_val(bus_wdata),
    .inc(lo_inc), .q(cnt_lo), .at_max(lo_max)
  );

  pa_byte_cnt #(.W(BYTE_W)) u_hi (
    .clk(clk), .rst_n(rst_n), .load(wr_hi), .load_val(bus_wdata),
    .inc(hi_inc), .q(cnt_hi), .at_max(hi_max)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ben_q  <= '0;
      ovf_q  <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.merge   <= bus_wdata[C_MERGE];
        ctrl_q.gated   <= bus_wdata[C_GATED];
        ctrl_q.pol     <= bus_wdata[C_POL];
        ctrl_q.ovf_ie  <= bus_wdata[C_OVF_IE];
        ctrl_q.edge_ie <= bus_wdata[C_EDGE_IE];
      end
      if (wr_ben) ben_q <= bus_wdata[1:0];
      ovf_q  <= (ovf_q  & ~(wr_flags & bus_wdata[F_OVF]))  | ovf_set;
      edge_q <= (edge_q & ~(wr_flags & bus_wdata[F_EDGE])) | edge_set;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[C_MERGE]   = ctrl_q.merge;
        bus_rdata[C_GATED]   = ctrl_q.gated;
        bus_rdata[C_POL]     = ctrl_q.pol;
        bus_rdata[C_OVF_IE]  = ctrl_q.ovf_ie;
        bus_rdata[C_EDGE_IE] = ctrl_q.edge_ie;
      end
      A_BEN:    bus_rdata[1:0] = ben_q;
      A_CNT_HI: bus_rdata = cnt_hi;
      A_CNT_LO: bus_rdata = cnt_lo;
      A_FLAGS: begin
        bus_rdata[F_OVF]  = ovf_q;
        bus_rdata[F_EDGE] = edge_q;
      end
      default:  bus_rdata = '0;
    endcase
  end

  assign ovf_flag  = ovf_q;
  assign edge_flag = edge_q;
  assign irq       = (ovf_q & ctrl_q.ovf_ie) | (edge_q & ctrl_q.edge_ie);
endmodule

// File: rtl/pulse_acc_chk.sv
module pulse_acc_chk
  import pa_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [2:0]        bus_addr,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic              merge,
  input logic [1:0]        ben,
  input logic [BYTE_W-1:0] cnt_hi,
  input logic [BYTE_W-1:0] cnt_lo,
  input logic              ovf_flag,
  input logic              edge_flag
);
  logic cnt_wr;
  assign cnt_wr = bus_we && (bus_addr == A_CNT_HI || bus_addr == A_CNT_LO);

  // R1: unimplemented control bits read as zero
  p_ctrl_pad_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CTRL) |-> (bus_rdata[7] == 1'b0 && bus_rdata[3:2] == 2'b00));

  // R2: disabled low byte holds its value in split mode
  p_lo_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!merge && !ben[0] && !(bus_we && bus_addr == A_CNT_LO)) |=> $stable(cnt_lo));

  // R4: merged count advances by at most one per cycle
  p_merged_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (merge && !cnt_wr) |=>
      ({cnt_hi, cnt_lo} == $past({cnt_hi, cnt_lo}) ||
       {cnt_hi, cnt_lo} == $past({cnt_hi, cnt_lo}) + 1'b1));

  // R6: edge flag cannot rise while split
  p_edge_split_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !merge |=> !$rose(edge_flag));

  // R7: overflow sets only on a wrap of the full count
  p_ovf_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past({cnt_hi, cnt_lo}) == {(2*BYTE_W){1'b1}} &&
                         {cnt_hi, cnt_lo} == '0));

  // R10: a write loads the low byte directly
  p_load_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CNT_LO) |=> (cnt_lo == $past(bus_wdata)));
endmodule

bind pulse_acc_top pulse_acc_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .merge(ctrl_q.merge),
  .ben(ben_q), .cnt_hi(cnt_hi), .cnt_lo(cnt_lo),
  .ovf_flag(ovf_flag), .edge_flag(edge_flag)
);

// File: tb/pulse_acc_top_tb.sv
module pulse_acc_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [BW-1:0] bus_wdata = '0;
  logic [BW-1:0] bus_rdata;
  logic          pin_a = 1'b0, pin_b = 1'b0, tick = 1'b0;
  logic          ovf_flag, edge_flag, irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_acc_top #(.BYTE_W(BW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_a(pin_a),
    .pin_b(pin_b), .tick(tick), .ovf_flag(ovf_flag),
    .edge_flag(edge_flag), .irq(irq)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [BW-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    #1 v = int'(bus_rdata);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic set_a(input logic v);
    @(negedge clk); pin_a = v; settle();
  endtask

  task automatic set_b(input logic v);
    @(negedge clk); pin_b = v; settle();
  endtask

  task automatic t_reset();
    int v;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 reset value", v, 0);
    end
    wr(3'd0, 8'hFF);
    rd(3'd0, v);
    chk("R1 pad bits", v, 8'h73);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_split();
    int v;
    wr(3'd0, 8'h10);            // split, rising edges
    wr(3'd1, 8'h01);            // low byte only
    set_a(1); set_a(0); set_a(1); set_a(0);
    set_b(1); set_b(0);
    rd(3'd3, v); chk("R2 lo counts pin_a", v, 2);
    rd(3'd2, v); chk("R2 hi disabled", v, 0);
    rd(3'd4, v); chk("R6 no edge flag split", v, 0);
    wr(3'd1, 8'h02);            // high byte only
    set_b(1); set_b(0); set_a(1); set_a(0);
    rd(3'd2, v); chk("R2 hi counts pin_b", v, 1);
    rd(3'd3, v); chk("R2 lo disabled", v, 2);
    wr(3'd0, 8'h00);            // falling edges
    wr(3'd1, 8'h03);
    set_a(1); set_a(0);
    rd(3'd3, v); chk("R2 falling edge", v, 3);
  endtask

  task automatic t_merged_event();
    int v;
    wr(3'd1, 8'h00);            // byte enables off: ignored when merged
    wr(3'd2, 8'h00); wr(3'd3, 8'hFF);
    wr(3'd0, 8'h51);            // merge, event, rising, edge irq
    set_a(1);
    rd(3'd2, v); chk("R3 carry hi", v, 1);
    rd(3'd3, v); chk("R3 carry lo", v, 0);
    chk("R6 edge flag", int'(edge_flag), 1);
    chk("R9 irq edge", int'(irq), 1);
    set_b(1); set_b(0); set_a(0);
    rd(3'd3, v); chk("R4 pin_b and falling ignored", v, 0);
    wr(3'd4, 8'h02);            // clear ovf only
    chk("R8 write0 keeps edge", int'(edge_flag), 1);
    wr(3'd4, 8'h01);
    chk("R8 w1c edge", int'(edge_flag), 0);
    chk("R9 irq drops", int'(irq), 0);
  endtask

  task automatic t_gated();
    int v;
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd0, 8'h60);            // merge, gated, gate open while high
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
    end
    rd(3'd3, v); chk("R5 closed gate ignores ticks", v, 0);
    set_a(1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
    end
    chk("R6 no flag before trailing", int'(edge_flag), 0);
    set_a(0);
    rd(3'd3, v); chk("R5 gated count", v, 5);
    chk("R6 trailing gate edge", int'(edge_flag), 1);
    wr(3'd4, 8'h01);
    wr(3'd0, 8'h70);            // gate open while low
    @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
    rd(3'd3, v); chk("R5 low gate", v, 6);
  endtask

  task automatic t_overflow();
    int v;
    wr(3'd0, 8'h52);            // merge, event, rising, ovf irq
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    set_a(1);
    rd(3'd2, v); chk("R7 wrap hi", v, 0);
    rd(3'd3, v); chk("R7 wrap lo", v, 0);
    chk("R7 ovf set", int'(ovf_flag), 1);
    chk("R9 irq ovf", int'(irq), 1);
    set_a(0); set_a(1);
    chk("R7 sticky", int'(ovf_flag), 1);
    wr(3'd4, 8'h02);
    chk("R8 w1c ovf", int'(ovf_flag), 0);
    set_a(0);
  endtask

  task automatic t_load_priority();
    int v;
    wr(3'd0, 8'h50);
    wr(3'd2, 8'h12); wr(3'd3, 8'h34);
    @(negedge clk); pin_a = 1'b1;          // increment lands 3 edges later
    @(negedge clk);
    @(negedge clk); bus_we = 1'b1; bus_addr = 3'd3; bus_wdata = 8'h40;
    @(negedge clk); bus_we = 1'b0;
    settle();
    rd(3'd3, v); chk("R10 write beats increment", v, 8'h40);
    rd(3'd2, v); chk("R10 hi untouched", v, 8'h12);
    set_a(0); set_a(1);
    rd(3'd3, v); chk("R10 counting resumes", v, 8'h41);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_split();
    t_merged_event();
    t_gated();
    t_overflow();
    t_load_priority();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule